// File: doc/BRIEF.md
# Indexed Block-Transfer Two-Wire Register Slave

This block is a slave on a two-wire SMBus-style bus. It gives a host access to a small bank of 8-bit configuration registers. The clock and data lines are sampled in the system clock domain. Each line passes through a synchronizer and a glitch filter. Start, repeated start and stop are detected from the filtered lines. The slave answers to one fixed 7-bit device address. The registers themselves sit outside the block and are reached through a plain parallel port: an address, write data, a one-cycle write strobe and combinational read data.

Every write frame carries three things after the write address: a starting index, then a byte count, then the data. The slave acknowledges each data byte up to the count and stores it at an index that advances and wraps around the bank. A read frame first sets the index with a short write frame. A repeated start and the read address follow. The slave then returns the most recently written count, followed by register contents from the index onward, until the host answers with a not-acknowledge.

The slave drives the data line only as an open-drain pull-down. It changes what it drives only while the clock line is low. General call and clock stretching are not supported.

Top module: `smb_blk_slave`

## Requirements
- R1: The slave acknowledges (pulls the data line low during the ninth clock) an address byte whose upper seven bits equal DEV_ADDR (default 0x6A, so 0xD4 writes and 0xD5 reads), and also acknowledges the index byte and the count byte that follow a write address.
- R2: After an address byte that does not match, the slave gives no acknowledge, makes no register write and leaves the data line released until the next start condition.
- R3: In a write frame (address, index N, count X, data), each of the first X data bytes is acknowledged and produces exactly one single-cycle reg_we_o pulse, with reg_addr_o equal to the current index and reg_wdata_o equal to the byte.
- R4: Data bytes beyond the count in a write frame are not acknowledged and produce no register write.
- R5: The index byte is reduced modulo NREG. The index advances after every data byte and wraps from NREG-1 to 0. reg_addr_o stays below NREG.
- R6: After a repeated start and a matching read address, the first byte sent is the last count byte written (NREG after reset). The next bytes are read from the register bank starting at the stored index, most significant bit first.
- R7: A not-acknowledge from the host after a read byte ends the transfer. The data line then stays released until the next start condition.
- R8: The slave changes sda_pull_o only while the filtered clock line is low, except for the release that follows a start or stop condition.
- R9: During and after reset, sda_pull_o and reg_we_o are low.
- R10: A start or repeated start condition in any state restarts address reception. A stop condition returns the slave to idle.
- R11: A pulse on either bus line that lasts fewer than FILT_LEN system clocks is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 = pull the data line low (open-drain enable) |
| reg_addr_o | output | $clog2(NREG) | Register index for the access |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | Single-cycle register write strobe |
| reg_rdata_i | input | 8 | Register read data for reg_addr_o, combinational |

## Verification
A bad bit counter or a wrong state shows on the bus within one byte time. The slave then acknowledges in the wrong clock slot, or returns shifted read data that the host samples at the next high phase. A corrupt index or count appears at the register port on the very next write strobe, as a wrong address or as a strobe too many or too few. A drive change while the clock is high is caught in the same system clock. The bench checks every system clock against a queue of the writes it expects. It also checks each sampled bus bit against its own model of the register bank.

// File: rtl/smb_blk_pkg.sv
package smb_blk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_IDX, ST_CNT, ST_WR, ST_RD, ST_SKIP
  } smb_st_e;
endpackage

// File: rtl/smb_line_filt.sv
module smb_line_filt #(
  parameter int FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          s1_q, s2_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      cnt_q  <= '0;
      line_o <= 1'b1;
    end else begin
      s1_q <= line_i;
      s2_q <= s1_q;
      if (s2_q == line_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        line_o <= s2_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // output only follows a level the synchronizer presented
  p_filt_follow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o != $past(line_o)) |-> ($past(s2_q) == line_o));
endmodule

// File: rtl/smb_bus_cond.sv
module smb_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
  assign rise_o  = scl_i & ~scl_q;
  assign fall_o  = ~scl_i & scl_q;
endmodule

// File: rtl/smb_blk_fsm.sv
module smb_blk_fsm
  import smb_blk_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6A,
  parameter int         NREG     = 7,
  parameter int         AW       = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic [7:0]    rdata_i,
  output logic          pull_o,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    wdata_o,
  output logic          we_o
);
  localparam logic [7:0] NREG8 = 8'(NREG);

  smb_st_e       st_q, nxt_q;
  logic          ack_ph_q;
  logic [3:0]    bit_q;
  logic [7:0]    rx_q, tx_q, ld_q, cnt_q, rem_q;
  logic [AW-1:0] ptr_q, wa_q;
  logic [7:0]    idx_mod;

  assign idx_mod = rx_q % NREG8;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(NREG - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; nxt_q <= ST_IDLE; ack_ph_q <= 1'b0; bit_q <= '0;
      rx_q <= '0; tx_q <= '0; ld_q <= '0; cnt_q <= NREG8; rem_q <= '0;
      ptr_q <= '0; wa_q <= '0; wdata_o <= '0; we_o <= 1'b0; pull_o <= 1'b0;
    end else begin
      we_o <= 1'b0;
      if (start_i) begin
        st_q <= ST_ADDR; ack_ph_q <= 1'b0; bit_q <= '0; pull_o <= 1'b0;
      end else if (stop_i) begin
        st_q <= ST_IDLE; ack_ph_q <= 1'b0; bit_q <= '0; pull_o <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_IDX, ST_CNT, ST_WR: begin
            if (!ack_ph_q) begin
              if (rise_i) begin
                rx_q  <= {rx_q[6:0], sda_i};
                bit_q <= bit_q + 1'b1;
              end else if (fall_i && bit_q == 4'd8) begin
                ack_ph_q <= 1'b1;
                bit_q    <= '0;
                unique case (st_q)
                  ST_ADDR: begin
                    if (rx_q[7:1] == DEV_ADDR) begin
                      pull_o <= 1'b1;
                      nxt_q  <= rx_q[0] ? ST_RD : ST_IDX;
                      ld_q   <= cnt_q;
                    end else begin
                      nxt_q <= ST_SKIP;
                    end
                  end
                  ST_IDX: begin
                    ptr_q <= idx_mod[AW-1:0]; pull_o <= 1'b1; nxt_q <= ST_CNT;
                  end
                  ST_CNT: begin
                    cnt_q <= rx_q; rem_q <= rx_q; pull_o <= 1'b1; nxt_q <= ST_WR;
                  end
                  default: begin
                    nxt_q <= ST_WR;
                    if (rem_q != '0) begin
                      we_o <= 1'b1; wa_q <= ptr_q; wdata_o <= rx_q;
                      ptr_q <= inc(ptr_q); rem_q <= rem_q - 1'b1; pull_o <= 1'b1;
                    end
                  end
                endcase
              end
            end else if (fall_i) begin
              ack_ph_q <= 1'b0;
              st_q     <= nxt_q;
              if (nxt_q == ST_RD) begin
                pull_o <= ~ld_q[7];
                tx_q   <= {ld_q[6:0], 1'b0};
                bit_q  <= 4'd1;
              end else begin
                pull_o <= 1'b0;
              end
            end
          end
          ST_RD: begin
            if (!ack_ph_q) begin
              if (fall_i) begin
                if (bit_q == 4'd8) begin
                  pull_o <= 1'b0; ack_ph_q <= 1'b1; bit_q <= '0;
                end else begin
                  pull_o <= ~tx_q[7]; tx_q <= {tx_q[6:0], 1'b0}; bit_q <= bit_q + 1'b1;
                end
              end
            end else if (rise_i) begin
              if (sda_i) begin
                st_q <= ST_SKIP; ack_ph_q <= 1'b0;
              end else begin
                ld_q <= rdata_i; ptr_q <= inc(ptr_q);
              end
            end else if (fall_i) begin
              ack_ph_q <= 1'b0;
              pull_o   <= ~ld_q[7];
              tx_q     <= {ld_q[6:0], 1'b0};
              bit_q    <= 4'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign addr_o = we_o ? wa_q : ptr_q;

  p_drive_scl_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_o != $past(pull_o)) |-> (!$past(scl_i) || $past(start_i) || $past(stop_i)));
  p_skip_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SKIP) |-> !pull_o);
  p_we_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o);
  p_addr_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(addr_o) < NREG);
endmodule

// File: rtl/smb_blk_slave.sv
module smb_blk_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h6A,
  parameter int         NREG     = 7,
  parameter int         FILT_LEN = 3,
  localparam int        AW       = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_pull_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [7:0]    reg_wdata_o,
  output logic          reg_we_o,
  input  logic [7:0]    reg_rdata_i
);
  logic [1:0] raw, filt;
  logic       start, stop, rise, fall;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    smb_line_filt #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i(clk_i), .rst_ni(rst_ni), .line_i(raw[g]), .line_o(filt[g])
    );
  end

  smb_bus_cond u_cond (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(filt[1]), .sda_i(filt[0]),
    .start_o(start), .stop_o(stop), .rise_o(rise), .fall_o(fall)
  );

  smb_blk_fsm #(.DEV_ADDR(DEV_ADDR), .NREG(NREG), .AW(AW)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(filt[1]), .sda_i(filt[0]),
    .start_i(start), .stop_i(stop), .rise_i(rise), .fall_i(fall),
    .rdata_i(reg_rdata_i), .pull_o(sda_pull_o), .addr_o(reg_addr_o),
    .wdata_o(reg_wdata_o), .we_o(reg_we_o)
  );
endmodule

// File: tb/tb_smb_blk_slave.sv
module tb_smb_blk_slave;
  localparam int Q = 25;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1, glitch = 1'b0;
  logic       sda_pull_o, reg_we_o;
  logic [2:0] reg_addr_o;
  logic [7:0] reg_wdata_o, reg_rdata_i;
  logic       sda_bus;

  int tests = 0, fails = 0;
  logic [7:0]  bank [0:6];
  logic [7:0]  expb [0:6];
  logic [10:0] wq[$];
  logic        scl_prev = 1'b1, pull_prev = 1'b0;

  always #10 clk = ~clk;

  assign sda_bus     = sda_m & ~sda_pull_o;
  assign reg_rdata_i = (reg_addr_o < 3'd7) ? bank[reg_addr_o] : 8'h00;

  smb_blk_slave dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m & ~glitch), .sda_i(sda_bus),
    .sda_pull_o(sda_pull_o), .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o),
    .reg_we_o(reg_we_o), .reg_rdata_i(reg_rdata_i)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-clock reference: expected write queue and drive-while-high rule
  always @(negedge clk) begin
    if (rst_ni) begin
      if (reg_we_o) begin
        if (wq.size() == 0) begin
          chk(1'b0, "R4 unexpected write", {reg_addr_o, reg_wdata_o}, 0);
        end else begin
          logic [10:0] e;
          e = wq.pop_front();
          chk({reg_addr_o, reg_wdata_o} == e, "R3 write addr/data",
              {reg_addr_o, reg_wdata_o}, e);
          if (reg_addr_o < 3'd7) bank[reg_addr_o] = reg_wdata_o;
        end
      end
      if (scl_m && scl_prev && sda_pull_o != pull_prev)
        chk(1'b0, "R8 drive change while clock high", sda_pull_o, pull_prev);
    end
    scl_prev  = scl_m;
    pull_prev = sda_pull_o;
  end

  task automatic wq_q(); repeat (Q) @(negedge clk); endtask

  task automatic bit_x(input logic b, input logic gl, output logic s);
    sda_m = b; wq_q();
    scl_m = 1'b1;
    if (gl) begin
      repeat (8) @(negedge clk);
      glitch = 1'b1; @(negedge clk); glitch = 1'b0;
      repeat (Q - 9) @(negedge clk);
    end else wq_q();
    s = sda_bus; wq_q();
    scl_m = 1'b0; wq_q();
  endtask

  task automatic m_start(); sda_m = 1'b0; wq_q(); scl_m = 1'b0; wq_q(); endtask
  task automatic m_rstart();
    sda_m = 1'b1; wq_q(); scl_m = 1'b1; wq_q(); sda_m = 1'b0; wq_q(); scl_m = 1'b0; wq_q();
  endtask
  task automatic m_stop(); sda_m = 1'b0; wq_q(); scl_m = 1'b1; wq_q(); sda_m = 1'b1; wq_q(); endtask

  task automatic wr_byte(input logic [7:0] b, input logic exp_ack, input string tag,
                         input int gl_bit = -1);
    logic s;
    for (int i = 7; i >= 0; i--) bit_x(b[i], i == gl_bit, s);
    bit_x(1'b1, 1'b0, s);
    chk(s == !exp_ack, tag, s, !exp_ack);
  endtask

  task automatic rd_byte(input logic [7:0] exp, input logic m_ack, input string tag);
    logic s;
    logic [7:0] v;
    v = '0;
    for (int i = 7; i >= 0; i--) begin
      bit_x(1'b1, 1'b0, s);
      v = {v[6:0], s};
    end
    bit_x(!m_ack, 1'b0, s);
    chk(v == exp, tag, v, exp);
  endtask

  task automatic exp_wr(input logic [2:0] a, input logic [7:0] d);
    wq.push_back({a, d});
    expb[a] = d;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 7; i++) begin
      bank[i] = 8'h10 + 8'(i);
      expb[i] = 8'h10 + 8'(i);
    end
    repeat (3) @(negedge clk);
    chk(sda_pull_o == 1'b0, "R9 pull in reset", sda_pull_o, 0);
    chk(reg_we_o == 1'b0, "R9 we in reset", reg_we_o, 0);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk);
    chk(sda_pull_o == 1'b0 && reg_we_o == 1'b0, "R9 idle after reset",
        {sda_pull_o, reg_we_o}, 0);

    // R6: read with reset count
    m_start();
    wr_byte(8'hD4, 1'b1, "R1 write address ack");
    wr_byte(8'h02, 1'b1, "R1 index ack");
    m_rstart();
    wr_byte(8'hD5, 1'b1, "R1 read address ack");
    rd_byte(8'd7, 1'b1, "R6 reset count");
    rd_byte(expb[2], 1'b1, "R6 data at index");
    rd_byte(expb[3], 1'b0, "R6 next data");
    m_stop();

    // R3/R5: block write wrapping, R4: extra byte
    exp_wr(3'd5, 8'hA1); exp_wr(3'd6, 8'hA2); exp_wr(3'd0, 8'hA3); exp_wr(3'd1, 8'hA4);
    m_start();
    wr_byte(8'hD4, 1'b1, "R1 write address ack");
    wr_byte(8'h05, 1'b1, "R1 index ack");
    wr_byte(8'h04, 1'b1, "R1 count ack");
    wr_byte(8'hA1, 1'b1, "R3 data ack");
    wr_byte(8'hA2, 1'b1, "R3 data ack");
    wr_byte(8'hA3, 1'b1, "R5 data ack after wrap");
    wr_byte(8'hA4, 1'b1, "R3 data ack");
    wr_byte(8'hEE, 1'b0, "R4 extra byte nack");
    m_stop();
    repeat (10) @(negedge clk);
    chk(wq.size() == 0, "R3 all writes seen", wq.size(), 0);

    // R6/R5 read back across wrap, R7 nack ends transfer
    m_start();
    wr_byte(8'hD4, 1'b1, "R1 write address ack");
    wr_byte(8'h05, 1'b1, "R1 index ack");
    m_rstart();
    wr_byte(8'hD5, 1'b1, "R1 read address ack");
    rd_byte(8'd4, 1'b1, "R6 last written count");
    rd_byte(expb[5], 1'b1, "R6 data 5");
    rd_byte(expb[6], 1'b1, "R6 data 6");
    rd_byte(expb[0], 1'b1, "R5 read wrap to 0");
    rd_byte(expb[1], 1'b1, "R6 data 1");
    rd_byte(expb[2], 1'b0, "R6 data 2");
    rd_byte(8'hFF, 1'b0, "R7 released after host nack");
    m_stop();

    // R2: mismatch, R10: repeated start recovers
    m_start();
    wr_byte(8'hA0, 1'b0, "R2 mismatch nack");
    wr_byte(8'h00, 1'b0, "R2 quiet after mismatch");
    exp_wr(3'd0, 8'h5A);
    m_rstart();
    wr_byte(8'hD4, 1'b1, "R10 address after restart");
    wr_byte(8'h00, 1'b1, "R1 index ack");
    wr_byte(8'h01, 1'b1, "R1 count ack");
    wr_byte(8'h5A, 1'b1, "R10 data after restart");
    m_stop();

    // R5: index reduced modulo bank size (9 -> 2)
    exp_wr(3'd2, 8'h3C);
    m_start();
    wr_byte(8'hD4, 1'b1, "R1 write address ack");
    wr_byte(8'h09, 1'b1, "R5 large index ack");
    wr_byte(8'h01, 1'b1, "R1 count ack");
    wr_byte(8'h3C, 1'b1, "R5 data ack");
    m_stop();

    // R11: one-cycle clock glitch during bit 4
    exp_wr(3'd3, 8'h96);
    m_start();
    wr_byte(8'hD4, 1'b1, "R1 write address ack");
    wr_byte(8'h03, 1'b1, "R1 index ack");
    wr_byte(8'h01, 1'b1, "R1 count ack");
    wr_byte(8'h96, 1'b1, "R11 data ack with glitch", 4);
    m_stop();

    // R6: final read back of the bank
    m_start();
    wr_byte(8'hD4, 1'b1, "R1 write address ack");
    wr_byte(8'h00, 1'b1, "R1 index ack");
    m_rstart();
    wr_byte(8'hD5, 1'b1, "R1 read address ack");
    rd_byte(8'd1, 1'b1, "R6 count after single write");
    rd_byte(expb[0], 1'b1, "R10 data 0");
    rd_byte(expb[1], 1'b1, "R6 data 1");
    rd_byte(expb[2], 1'b1, "R5 data 2");
    rd_byte(expb[3], 1'b0, "R11 data 3");
    m_stop();

    repeat (20) @(negedge clk);
    chk(wq.size() == 0, "R4 no missing writes", wq.size(), 0);
    chk(sda_pull_o == 1'b0, "R10 released after stop", sda_pull_o, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule